// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two direction predictors that use different history. The first is a per-branch predictor: a table of shift registers, selected by bits of the branch address, records each branch's own recent outcomes, and that pattern selects a saturating counter. The second is a path predictor: a single shift register holds the outcomes of every recent branch, and that pattern selects a counter in a second table. A third table of saturating counters, also selected by the shared path history, learns which of the two predictors has been right more often in that context, and the final answer comes from that predictor.

The front end presents a branch address on the lookup port and receives the final direction together with both component guesses in the same cycle. When the branch resolves, the back end presents the address, the real outcome and the two component guesses it kept from the lookup on the update port. The update takes effect at the next clock edge. Histories are not restored after a misprediction: updates are assumed to arrive in program order from resolved branches only.

Top module: `tournament_bp`

## Requirements
- R1: After reset every direction counter holds 1 (weakly not taken), every chooser counter holds 1 (favours the per-branch side), and all history bits are 0, so every lookup returns 0 on all three prediction outputs.
- R2: An update with outcome 1 raises each counter it writes by one, up to a ceiling of 3, and the counter stays at 3 after further taken updates.
- R3: An update with outcome 0 lowers each counter it writes by one, down to a floor of 0, and a counter predicts taken exactly when its value is 2 or 3.
- R4: The per-branch guess reads the history entry at address bits [LIDX_W+1:2] and uses that history value as the index of its counter. No other address bits affect it.
- R5: The path guess reads the counter indexed by the current path history.
- R6: `pred_taken` equals `pred_global` when the chooser counter indexed by the path history is 2 or more, and equals `pred_local` otherwise.
- R7: The chooser entry at the current path history changes only when `upd_local` and `upd_global` differ. It then moves up when `upd_global` equals the outcome and down when `upd_local` equals the outcome.
- R8: On every update, the per-branch counter at the updated branch's current history and the path counter at the current path history both step toward the outcome.
- R9: On every update, the path history shifts left by one and takes the outcome into bit 0. The oldest bit is dropped.
- R10: On every update, only the history entry selected by `upd_pc` shifts left and takes the outcome into bit 0. All other entries keep their value.
- R11: When `upd_valid` is 0, no counter and no history changes, whatever the other update inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Branch address to predict |
| pred_taken | output | 1 | Final direction picked by the chooser |
| pred_local | output | 1 | Per-branch history component guess |
| pred_global | output | 1 | Path history component guess |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_local | input | 1 | Per-branch guess kept from the lookup |
| upd_global | input | 1 | Path guess kept from the lookup |

## Verification
The bound checker covers, on every cycle, how the path history register moves: it shifts in the outcome on an update and holds otherwise. It also checks that the chooser is never written while the component guesses agree or no update is present, and that the final output agrees with both components when they agree. Counter saturation, the indexing of both tables, and the direction the chooser learns in can only be seen through the bench's scenarios. The bench compares every lookup against its own table model. It drives saturation runs, loop-shaped outcome patterns, pseudo-random traffic with arbitrary component guesses, and idle cycles. It also sweeps all history slots so that updates which strayed to the wrong entry are exposed.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef enum logic {
    SRC_LOCAL  = 1'b0,
    SRC_GLOBAL = 1'b1
  } tbp_src_e;

  typedef struct packed {
    logic valid;
    logic taken;
    logic local_guess;
    logic global_guess;
  } tbp_upd_s;

  localparam int unsigned TBP_PC_LSB = 2;

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
  parameter int IDX_W = 10,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_high,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_RST = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] ctr_cur;
  logic [CTR_W-1:0] ctr_nxt;

  always_comb begin
    ctr_cur = ctr_q[wr_idx];
    ctr_nxt = ctr_cur;
    if (wr_up) begin
      if (ctr_cur != CTR_MAX) ctr_nxt = ctr_cur + 1'b1;
    end else begin
      if (ctr_cur != '0) ctr_nxt = ctr_cur - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_RST;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= ctr_nxt;
    end
  end

  assign rd_high = ctr_q[rd_idx][CTR_W-1];

endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [HIST_W-1:0] lk_hist,
  input  logic [IDX_W-1:0]  up_idx,
  output logic [HIST_W-1:0] up_hist,
  input  logic              shift_en,
  input  logic              shift_bit
);

  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];
  logic [HIST_W-1:0] hist_nxt;

  assign lk_hist = hist_q[lk_idx];
  assign up_hist = hist_q[up_idx];

  always_comb begin
    hist_nxt = {up_hist[HIST_W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (shift_en) begin
      hist_q[up_idx] <= hist_nxt;
    end
  end

endmodule

// File: rtl/tbp_path_reg.sv
module tbp_path_reg #(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_nxt;

  always_comb begin
    hist_nxt = hist_q;
    if (shift_en) hist_nxt = {hist_q[HIST_W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_nxt;
  end

  assign hist = hist_q;

endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
  import tbp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int LIDX_W  = 10,
  parameter int LHIST_W = 10,
  parameter int GHIST_W = 12,
  parameter int CTR_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_local,
  output logic            pred_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local,
  input  logic            upd_global
);

  localparam int PC_LO = TBP_PC_LSB;
  localparam int PC_HI = PC_LO + LIDX_W - 1;

  tbp_upd_s          upd;
  logic [LIDX_W-1:0] pred_slot;
  logic [LIDX_W-1:0] upd_slot;
  logic [LHIST_W-1:0] pred_lhist;
  logic [LHIST_W-1:0] upd_lhist;
  logic [GHIST_W-1:0] ghist_q;
  logic              chooser_high;
  logic              cho_we;
  logic              global_right;
  tbp_src_e          pick;

  assign upd = '{valid: upd_valid, taken: upd_taken,
                 local_guess: upd_local, global_guess: upd_global};

  assign pred_slot = pred_pc[PC_HI:PC_LO];
  assign upd_slot  = upd_pc[PC_HI:PC_LO];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc[PC_W-1:PC_HI+1], pred_pc[PC_LO-1:0],
                            upd_pc[PC_W-1:PC_HI+1], upd_pc[PC_LO-1:0]};

  tbp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (pred_slot),
    .lk_hist  (pred_lhist),
    .up_idx   (upd_slot),
    .up_hist  (upd_lhist),
    .shift_en (upd.valid),
    .shift_bit(upd.taken)
  );

  tbp_path_reg #(.HIST_W(GHIST_W)) u_ghist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd.valid),
    .shift_bit(upd.taken),
    .hist     (ghist_q)
  );

  tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(CTR_W)) u_local_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (pred_lhist),
    .rd_high(pred_local),
    .wr_en  (upd.valid),
    .wr_idx (upd_lhist),
    .wr_up  (upd.taken)
  );

  tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CTR_W)) u_global_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (ghist_q),
    .rd_high(pred_global),
    .wr_en  (upd.valid),
    .wr_idx (ghist_q),
    .wr_up  (upd.taken)
  );

  always_comb begin
    cho_we       = upd.valid && (upd.local_guess != upd.global_guess);
    global_right = (upd.global_guess == upd.taken);
  end

  tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CTR_W)) u_chooser (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (ghist_q),
    .rd_high(chooser_high),
    .wr_en  (cho_we),
    .wr_idx (ghist_q),
    .wr_up  (global_right)
  );

  always_comb begin
    pick       = chooser_high ? SRC_GLOBAL : SRC_LOCAL;
    pred_taken = (pick == SRC_GLOBAL) ? pred_global : pred_local;
  end

endmodule

// File: rtl/tournament_bp_checker.sv
module tournament_bp_checker #(
  parameter int GHIST_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic               upd_local,
  input logic               upd_global,
  input logic               pred_taken,
  input logic               pred_local,
  input logic               pred_global,
  input logic [GHIST_W-1:0] ghist,
  input logic               cho_we
);

  p_ghist_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist == {$past(ghist[GHIST_W-2:0]), $past(upd_taken)});

  p_ghist_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

  p_chooser_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_local == upd_global)) |-> !cho_we);

  p_chooser_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> !cho_we);

  p_pick_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_local == pred_global) |-> (pred_taken == pred_local));

endmodule

bind tournament_bp tournament_bp_checker #(.GHIST_W(GHIST_W)) u_tbp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_valid  (upd_valid),
  .upd_taken  (upd_taken),
  .upd_local  (upd_local),
  .upd_global (upd_global),
  .pred_taken (pred_taken),
  .pred_local (pred_local),
  .pred_global(pred_global),
  .ghist      (ghist_q),
  .cho_we     (cho_we)
);

// File: tb/tournament_bp_bench.sv
module tournament_bp_bench;

  localparam int PC_W    = 16;
  localparam int LIDX_W  = 3;
  localparam int LHIST_W = 4;
  localparam int GHIST_W = 4;
  localparam int CTR_W   = 2;
  localparam int NSLOT   = 1 << LIDX_W;
  localparam int NLC     = 1 << LHIST_W;
  localparam int NGC     = 1 << GHIST_W;

  logic            clk;
  logic            rst_n;
  logic [PC_W-1:0] pred_pc;
  logic            pred_taken, pred_local, pred_global;
  logic            upd_valid;
  logic [PC_W-1:0] upd_pc;
  logic            upd_taken, upd_local, upd_global;

  int n_cmp;
  int n_bad;
  bit done;

  int m_lh [NSLOT];
  int m_lc [NLC];
  int m_gc [NGC];
  int m_ch [NGC];
  int m_g;
  logic [15:0] lf;

  tournament_bp #(
    .PC_W(PC_W), .LIDX_W(LIDX_W), .LHIST_W(LHIST_W),
    .GHIST_W(GHIST_W), .CTR_W(CTR_W)
  ) u_tournament_bp (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_local(upd_local), .upd_global(upd_global)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int sat(int v, bit up);
    if (up) return (v < 3) ? v + 1 : 3;
    return (v > 0) ? v - 1 : 0;
  endfunction

  function automatic int slot_of(logic [PC_W-1:0] pc);
    return int'(pc[LIDX_W+1:2]);
  endfunction

  function automatic bit m_loc(logic [PC_W-1:0] pc);
    return m_lc[m_lh[slot_of(pc)]] >= 2;
  endfunction

  function automatic bit m_glb();
    return m_gc[m_g] >= 2;
  endfunction

  function automatic bit m_fin(logic [PC_W-1:0] pc);
    return (m_ch[m_g] >= 2) ? m_glb() : m_loc(pc);
  endfunction

  task automatic cmp1(string tag, string field, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b pc=%h time=%0t",
               tag, field, act, exp, pred_pc, $time);
    end
  endtask

  // Drive a lookup at the falling edge and compare all three outputs.
  task automatic look(string tag, logic [PC_W-1:0] pc);
    @(negedge clk);
    pred_pc = pc;
    #1;
    cmp1(tag, "R4 pred_local", pred_local, m_loc(pc));
    cmp1(tag, "R5 pred_global", pred_global, m_glb());
    cmp1(tag, "R6 pred_taken", pred_taken, m_fin(pc));
  endtask

  task automatic sweep(string tag);
    for (int s = 0; s < NSLOT; s++) look(tag, PC_W'((s << 2) | (lf & 16'hffe3)));
  endtask

  // One lookup followed by an update of the same branch.
  task automatic step(string tag, logic [PC_W-1:0] pc, bit t,
                      bit force_guess, bit gl, bit gg);
    bit ul, ug;
    int sl, lh;
    look(tag, pc);
    ul = force_guess ? gl : m_loc(pc);
    ug = force_guess ? gg : m_glb();
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
    upd_local = ul; upd_global = ug;
    @(posedge clk);
    sl = slot_of(pc);
    lh = m_lh[sl];
    m_lc[lh] = sat(m_lc[lh], t);
    m_gc[m_g] = sat(m_gc[m_g], t);
    if (ul != ug) m_ch[m_g] = sat(m_ch[m_g], ug == t);
    m_g = ((m_g << 1) | int'(t)) & (NGC - 1);
    m_lh[sl] = ((lh << 1) | int'(t)) & (NLC - 1);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic lf_next();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired before the run ended");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    lf = 16'hace1;
    rst_n = 1'b0; pred_pc = '0; upd_valid = 1'b0; upd_pc = '0;
    upd_taken = 1'b0; upd_local = 1'b0; upd_global = 1'b0;
    for (int i = 0; i < NSLOT; i++) m_lh[i] = 0;
    for (int i = 0; i < NLC; i++) m_lc[i] = 1;
    for (int i = 0; i < NGC; i++) begin m_gc[i] = 1; m_ch[i] = 1; end
    m_g = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, every slot predicts not taken
    for (int s = 0; s < NSLOT; s++) begin
      look("R1", PC_W'(s << 2));
      cmp1("R1", "reset pred_taken", pred_taken, 1'b0);
    end

    // R2: taken run past the ceiling on one branch
    for (int k = 0; k < 8; k++) step("R2", 16'h0004, 1'b1, 1'b0, 1'b0, 1'b0);
    look("R2", 16'h0004);
    cmp1("R2", "saturated high pred_taken", pred_taken, 1'b1);
    // R3: not-taken run past the floor
    for (int k = 0; k < 8; k++) step("R3", 16'h0004, 1'b0, 1'b0, 1'b0, 1'b0);
    look("R3", 16'h0004);
    cmp1("R3", "saturated low pred_taken", pred_taken, 1'b0);

    // R8/R9: loop-shaped outcomes on three branches
    for (int k = 0; k < 90; k++)
      step("R9", PC_W'(((k % 3) + 2) << 2), (k % 4) != 3, 1'b0, 1'b0, 1'b0);
    sweep("R8");

    // R7: pseudo-random traffic with arbitrary kept guesses
    for (int k = 0; k < 400; k++) begin
      lf_next();
      step("R7", lf, lf[7] ^ lf[2], lf[11], lf[5], lf[9]);
    end

    // R10: all history slots after random traffic
    sweep("R10");

    // R11: idle cycles with noisy update inputs change nothing
    for (int k = 0; k < 12; k++) begin
      lf_next();
      @(negedge clk);
      upd_valid = 1'b0; upd_pc = lf; upd_taken = lf[3];
      upd_local = lf[4]; upd_global = lf[6];
    end
    sweep("R11");

    // R4: upper address bits do not change the per-branch guess
    for (int k = 0; k < 40; k++) begin
      lf_next();
      step("R4", lf, lf[0], 1'b0, 1'b0, 1'b0);
      look("R4", {lf[15:LIDX_W+2] ^ 11'h5a5, lf[LIDX_W+1:0] ^ 5'h03});
    end

    finish_run();
  end

endmodule